// File: doc/BRIEF.md
# CAN Controller Interrupt Aggregation Unit

This block owns the interrupt-enable register of a CAN controller and turns the controller's status events into one status-change interrupt request. The protocol engine supplies three error sources: a one-cycle strobe whenever a fresh error code is recorded, a bus-off level and an error-passive level. Each source has its own enable. An enabled source that becomes active latches a sticky error-pending flag. A separate master error enable decides whether that pending flag drives the interrupt.

Wakeup and sleep-acknowledge strobes latch their own sticky flags whatever the enables hold. Each flag drives the interrupt only while its enable is 1. Software reaches the enable word at offset 0x14 and the status word at offset 0x04 through a single-cycle write and combinational read port. Status flags clear when software writes 1 to them.

Top module: `can_irq_agg`

## Requirements
- R1: During and after an active-low reset, the enable word reads 0x0000_0000, the status word reads 0 and `irq_o` is 0.
- R2: The enable word at offset 0x14 holds sleep-ack enable at bit 17, wakeup enable at bit 16, master error enable at bit 15, error-code enable at bit 11, bus-off enable at bit 10 and error-passive enable at bit 9. All other bits read 0 and ignore writes, so writing all ones reads back 0x0003_8E00.
- R3: A strobe on `lec_upd_i` sets the error-pending flag (status bit 0) at the next clock edge only while enable bit 11 is 1. With the enable at 0 the strobe has no effect.
- R4: A rising edge of `bus_off_i` sets the error-pending flag only while enable bit 10 is 1. A level held high does not set the flag again after software clears it.
- R5: A rising edge of `err_pass_i` sets the error-pending flag only while enable bit 9 is 1. A held level does not set it again.
- R6: The error-pending flag stays set until a write to offset 0x04 with bit 0 at 1. Writing 0 to that bit leaves the flag set.
- R7: When an enabled error set and a software clear of status bit 0 fall in the same cycle, the flag is 1 afterwards.
- R8: The pending error flag drives `irq_o` only while enable bit 15 is 1.
- R9: A `wake_i` strobe sets status bit 1. That flag drives `irq_o` only while enable bit 16 is 1. Writing 1 to bit 1 at offset 0x04 clears it.
- R10: A `sleep_ack_i` strobe sets status bit 2. That flag drives `irq_o` only while enable bit 17 is 1. Writing 1 to bit 2 at offset 0x04 clears it.
- R11: Writing the enable word never clears a latched status flag.
- R12: Any address other than 0x14 and 0x04 reads 0, and writes to it change no register.
- R13: `irq_o` is a combinational level. It follows the enable word in the same cycle, with no pulse shaping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| lec_upd_i | input | 1 | One-cycle strobe: new error code recorded |
| bus_off_i | input | 1 | Bus-off state level |
| err_pass_i | input | 1 | Error-passive state level |
| wake_i | input | 1 | One-cycle wakeup event strobe |
| sleep_ack_i | input | 1 | One-cycle sleep-acknowledge strobe |
| irq_o | output | 1 | Status-change interrupt request level |

## Verification
The bench builds the block with its default parameters: an 8-bit offset bus and the enable and status words at 0x14 and 0x04. The 8-bit offset bus lets the bench hit an undecoded offset (0x08) to show that such writes and reads are inert. Full 32-bit writes of all ones reach every reserved enable bit. Because the two offsets are distinct, the same vector sequence can interleave enable changes with status clears. That interleaving brings the set-versus-clear collision and the held-level cases within reach.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  localparam int unsigned REG_W = 32;

  // enable word bit positions
  localparam int unsigned EN_SLK = 17;
  localparam int unsigned EN_WKU = 16;
  localparam int unsigned EN_ERR = 15;
  localparam int unsigned EN_LEC = 11;
  localparam int unsigned EN_BOF = 10;
  localparam int unsigned EN_EPV = 9;

  localparam logic [REG_W-1:0] IER_MASK =
      (REG_W'(1) << EN_SLK) | (REG_W'(1) << EN_WKU) | (REG_W'(1) << EN_ERR) |
      (REG_W'(1) << EN_LEC) | (REG_W'(1) << EN_BOF) | (REG_W'(1) << EN_EPV);

  // status word bit positions
  localparam int unsigned ST_ERR = 0;
  localparam int unsigned ST_WKU = 1;
  localparam int unsigned ST_SLK = 2;
  localparam int unsigned ST_W   = 3;

  // error source order inside the summarizer
  localparam int unsigned SRC_LEC = 0;
  localparam int unsigned SRC_BOF = 1;
  localparam int unsigned SRC_EPV = 2;
  localparam int unsigned N_ERR_SRC = 3;

  typedef struct packed {
    logic slk;
    logic wku;
    logic err;
    logic lec;
    logic bof;
    logic epv;
  } ier_t;
endpackage

// File: rtl/can_irq_regs.sv
module can_irq_regs
  import can_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] IER_OFS = ADDR_W'('h14),
  parameter logic [ADDR_W-1:0] STS_OFS = ADDR_W'('h04)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [ST_W-1:0]   sts_i,
  output logic [REG_W-1:0]  ier_word_o,
  output logic [ST_W-1:0]   sts_clr_o,
  output logic [REG_W-1:0]  rdata_o
);
  logic [REG_W-1:0] ier_q;
  logic             hit_ier, hit_sts;

  assign hit_ier = (addr_i == IER_OFS);
  assign hit_sts = (addr_i == STS_OFS);

  // reserved bits are masked on entry so they stay zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               ier_q <= '0;
    else if (wr_i && hit_ier)  ier_q <= wdata_i & IER_MASK;
  end

  assign ier_word_o = ier_q;
  assign sts_clr_o  = (wr_i && hit_sts) ? wdata_i[ST_W-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    if (hit_ier)      rdata_o = ier_q;
    else if (hit_sts) rdata_o[ST_W-1:0] = sts_i;
  end
endmodule

// File: rtl/can_irq_err.sv
module can_irq_err #(
  parameter int unsigned N_SRC = 3,
  parameter logic [N_SRC-1:0] LVL_MASK = 3'b110  // 1: level source, edge-detected
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] en_i,
  output logic             set_o
);
  logic [N_SRC-1:0] hit;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    if (LVL_MASK[g]) begin : g_lvl
      logic prev_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= src_i[g];
      end
      assign hit[g] = src_i[g] & ~prev_q;
    end else begin : g_pls
      assign hit[g] = src_i[g];
    end
  end

  assign set_o = |(hit & en_i);
endmodule

// File: rtl/can_irq_flag.sv
module can_irq_flag #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= (q & ~clr_i) | set_i;
  end

  assign q_o = q;
endmodule

// File: rtl/can_irq_agg.sv
module can_irq_agg
  import can_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] IER_OFS = ADDR_W'('h14),
  parameter logic [ADDR_W-1:0] STS_OFS = ADDR_W'('h04)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              lec_upd_i,
  input  logic              bus_off_i,
  input  logic              err_pass_i,
  input  logic              wake_i,
  input  logic              sleep_ack_i,
  output logic              irq_o
);
  logic [REG_W-1:0]     ier_word;
  ier_t                 ier;
  logic [ST_W-1:0]      sts_q, sts_clr, sts_set;
  logic [N_ERR_SRC-1:0] err_src, err_en;
  logic                 err_set;

  can_irq_regs #(
    .ADDR_W (ADDR_W),
    .IER_OFS(IER_OFS),
    .STS_OFS(STS_OFS)
  ) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .sts_i     (sts_q),
    .ier_word_o(ier_word),
    .sts_clr_o (sts_clr),
    .rdata_o   (rdata_o)
  );

  always_comb begin
    ier.slk = ier_word[EN_SLK];
    ier.wku = ier_word[EN_WKU];
    ier.err = ier_word[EN_ERR];
    ier.lec = ier_word[EN_LEC];
    ier.bof = ier_word[EN_BOF];
    ier.epv = ier_word[EN_EPV];
  end

  always_comb begin
    err_src          = '0;
    err_src[SRC_LEC] = lec_upd_i;
    err_src[SRC_BOF] = bus_off_i;
    err_src[SRC_EPV] = err_pass_i;
    err_en           = '0;
    err_en[SRC_LEC]  = ier.lec;
    err_en[SRC_BOF]  = ier.bof;
    err_en[SRC_EPV]  = ier.epv;
  end

  can_irq_err #(
    .N_SRC   (N_ERR_SRC),
    .LVL_MASK(N_ERR_SRC'((1 << SRC_BOF) | (1 << SRC_EPV)))
  ) i_err (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .src_i (err_src),
    .en_i  (err_en),
    .set_o (err_set)
  );

  always_comb begin
    sts_set         = '0;
    sts_set[ST_ERR] = err_set;
    sts_set[ST_WKU] = wake_i;
    sts_set[ST_SLK] = sleep_ack_i;
  end

  can_irq_flag #(.W(ST_W)) i_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (sts_set),
    .clr_i (sts_clr),
    .q_o   (sts_q)
  );

  assign irq_o = (sts_q[ST_SLK] & ier.slk) |
                 (sts_q[ST_WKU] & ier.wku) |
                 (sts_q[ST_ERR] & ier.err);
endmodule

// File: rtl/can_irq_agg_chk.sv
module can_irq_agg_chk
  import can_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] IER_OFS = ADDR_W'('h14),
  parameter logic [ADDR_W-1:0] STS_OFS = ADDR_W'('h04)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic              lec_upd_i,
  input logic              bus_off_i,
  input logic              wake_i,
  input logic              sleep_ack_i,
  input logic              irq_o,
  input logic [REG_W-1:0]  ier_word,
  input logic [ST_W-1:0]   sts_q
);
  p_rsv_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == IER_OFS) |-> ((rdata_o & ~IER_MASK) == '0));

  p_ier_wr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == IER_OFS) |=> (ier_word == ($past(wdata_i) & IER_MASK)));

  p_lec_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lec_upd_i && ier_word[EN_LEC]) |=> sts_q[ST_ERR]);

  p_bof_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(bus_off_i) && ier_word[EN_BOF]) |=> sts_q[ST_ERR]);

  p_err_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_q[ST_ERR] && !(wr_i && addr_i == STS_OFS && wdata_i[ST_ERR])) |=> sts_q[ST_ERR]);

  p_set_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lec_upd_i && ier_word[EN_LEC] && wr_i && addr_i == STS_OFS && wdata_i[ST_ERR])
      |=> sts_q[ST_ERR]);

  p_err_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_q[ST_ERR] && ier_word[EN_ERR]) |-> irq_o);

  p_wake_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |=> sts_q[ST_WKU]);

  p_slp_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_ack_i |=> sts_q[ST_SLK]);

  p_keep_flags_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == IER_OFS) |=> ((sts_q & $past(sts_q)) == $past(sts_q)));
endmodule

bind can_irq_agg can_irq_agg_chk #(
  .ADDR_W (ADDR_W),
  .IER_OFS(IER_OFS),
  .STS_OFS(STS_OFS)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_i       (wr_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .lec_upd_i  (lec_upd_i),
  .bus_off_i  (bus_off_i),
  .wake_i     (wake_i),
  .sleep_ack_i(sleep_ack_i),
  .irq_o      (irq_o),
  .ier_word   (ier_word),
  .sts_q      (sts_q)
);

// File: tb/test_can_irq_agg.sv
module test_can_irq_agg;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int NV = 31;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [31:0]       wdata_i = '0;
  logic [31:0]       rdata_o;
  logic lec_upd_i = 1'b0, bus_off_i = 1'b0, err_pass_i = 1'b0, wake_i = 1'b0, sleep_ack_i = 1'b0;
  logic irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_irq_agg i_can_irq_agg (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .lec_upd_i(lec_upd_i), .bus_off_i(bus_off_i),
    .err_pass_i(err_pass_i), .wake_i(wake_i), .sleep_ack_i(sleep_ack_i), .irq_o(irq_o)
  );

  // {req[4], ev{lec,boff,epass,wake,sleep}[5], wr, waddr[8], wdata[32], raddr[8], exp_rdata[32], exp_irq}
  localparam logic [90:0] VEC [NV] = '{
    {4'd2,  5'b00000, 1'b1, 8'h14, 32'hFFFF_FFFF, 8'h14, 32'h0003_8E00, 1'b0}, // R2 reserved masked
    {4'd2,  5'b00000, 1'b1, 8'h14, 32'h0000_0000, 8'h14, 32'h0000_0000, 1'b0}, // R2
    {4'd3,  5'b10000, 1'b0, 8'h00, 32'h0,         8'h04, 32'h0,         1'b0}, // R3 disabled strobe
    {4'd3,  5'b00000, 1'b1, 8'h14, 32'h0000_0800, 8'h14, 32'h0000_0800, 1'b0}, // R3
    {4'd3,  5'b10000, 1'b0, 8'h00, 32'h0,         8'h04, 32'h1,         1'b0}, // R3 set, R8 no master
    {4'd8,  5'b00000, 1'b1, 8'h14, 32'h0000_8800, 8'h04, 32'h1,         1'b1}, // R8
    {4'd6,  5'b00000, 1'b1, 8'h04, 32'h0,         8'h04, 32'h1,         1'b1}, // R6 write 0 keeps
    {4'd6,  5'b00000, 1'b1, 8'h04, 32'h1,         8'h04, 32'h0,         1'b0}, // R6 clear
    {4'd4,  5'b00000, 1'b1, 8'h14, 32'h0000_8400, 8'h04, 32'h0,         1'b0}, // R4
    {4'd4,  5'b01000, 1'b0, 8'h00, 32'h0,         8'h04, 32'h1,         1'b1}, // R4 rising edge
    {4'd4,  5'b01000, 1'b1, 8'h04, 32'h1,         8'h04, 32'h0,         1'b0}, // R4 clear while high
    {4'd4,  5'b01000, 1'b0, 8'h00, 32'h0,         8'h04, 32'h0,         1'b0}, // R4 held level no reset
    {4'd4,  5'b00000, 1'b0, 8'h00, 32'h0,         8'h04, 32'h0,         1'b0}, // R4 fall
    {4'd5,  5'b00000, 1'b1, 8'h14, 32'h0000_8200, 8'h04, 32'h0,         1'b0}, // R5
    {4'd5,  5'b00100, 1'b0, 8'h00, 32'h0,         8'h04, 32'h1,         1'b1}, // R5 rising edge
    {4'd5,  5'b00100, 1'b1, 8'h04, 32'h1,         8'h04, 32'h0,         1'b0}, // R5 clear while high
    {4'd5,  5'b00100, 1'b0, 8'h00, 32'h0,         8'h04, 32'h0,         1'b0}, // R5 held level
    {4'd5,  5'b00000, 1'b0, 8'h00, 32'h0,         8'h04, 32'h0,         1'b0}, // R5 fall
    {4'd4,  5'b01000, 1'b0, 8'h00, 32'h0,         8'h04, 32'h0,         1'b0}, // R4 edge, enable off
    {4'd7,  5'b00000, 1'b1, 8'h14, 32'h0000_8800, 8'h04, 32'h0,         1'b0}, // R7
    {4'd7,  5'b10000, 1'b1, 8'h04, 32'h1,         8'h04, 32'h1,         1'b1}, // R7 set beats clear
    {4'd6,  5'b00000, 1'b1, 8'h04, 32'h1,         8'h04, 32'h0,         1'b0}, // R6
    {4'd9,  5'b00010, 1'b0, 8'h00, 32'h0,         8'h04, 32'h2,         1'b0}, // R9 latched, gated off
    {4'd9,  5'b00000, 1'b1, 8'h14, 32'h0001_0000, 8'h04, 32'h2,         1'b1}, // R9
    {4'd10, 5'b00001, 1'b0, 8'h00, 32'h0,         8'h04, 32'h6,         1'b1}, // R10 latched
    {4'd10, 5'b00000, 1'b1, 8'h14, 32'h0002_0000, 8'h04, 32'h6,         1'b1}, // R10 gated on
    {4'd11, 5'b00000, 1'b1, 8'h14, 32'h0000_0000, 8'h04, 32'h6,         1'b0}, // R11 flags kept
    {4'd10, 5'b00000, 1'b1, 8'h04, 32'h4,         8'h04, 32'h2,         1'b0}, // R10 clear
    {4'd9,  5'b00000, 1'b1, 8'h04, 32'h2,         8'h04, 32'h0,         1'b0}, // R9 clear
    {4'd12, 5'b00000, 1'b1, 8'h08, 32'hFFFF_FFFF, 8'h14, 32'h0,         1'b0}, // R12 write ignored
    {4'd12, 5'b00000, 1'b0, 8'h00, 32'h0,         8'h08, 32'h0,         1'b0}  // R12 reads zero
  };

  task automatic chk(input bit ok, input int req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input int req);
    addr_i = a;
    #1;
    chk(rdata_o == exp, req, "rdata", rdata_o, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog: actual=%h expected=%h", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  logic [90:0] v;
  initial begin
    // R1: values during reset
    #3;
    rd_chk(8'h14, 32'h0, 1);
    rd_chk(8'h04, 32'h0, 1);
    chk(irq_o == 1'b0, 1, "irq in reset", {31'd0, irq_o}, 32'd0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    rd_chk(8'h14, 32'h0, 1);

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      @(negedge clk);
      {lec_upd_i, bus_off_i, err_pass_i, wake_i, sleep_ack_i} = v[86:82];
      wr_i    = v[81];
      addr_i  = v[80:73];
      wdata_i = v[72:41];
      @(posedge clk);
      #1;
      wr_i = 1'b0; lec_upd_i = 1'b0; wake_i = 1'b0; sleep_ack_i = 1'b0;
      addr_i = v[40:33];
      #1;
      chk(rdata_o == v[32:1], int'(v[90:87]), "vector rdata", rdata_o, v[32:1]);
      chk(irq_o == v[0], int'(v[90:87]), "vector irq", {31'd0, irq_o}, {31'd0, v[0]});
    end

    // R13: irq follows the enable word combinationally in the cycle of the write edge
    @(negedge clk);
    wake_i = 1'b1;
    @(posedge clk); #1; wake_i = 1'b0;
    @(negedge clk);
    wr_i = 1'b1; addr_i = 8'h14; wdata_i = 32'h0001_0000;
    @(posedge clk); #1; wr_i = 1'b0;
    chk(irq_o == 1'b1, 13, "irq level after enable", {31'd0, irq_o}, 32'd1);
    repeat (3) @(negedge clk);
    chk(irq_o == 1'b1, 13, "irq level held", {31'd0, irq_o}, 32'd1);

    // R1: reset mid-run clears everything
    rst_ni = 1'b0;
    #1;
    rd_chk(8'h14, 32'h0, 1);
    rd_chk(8'h04, 32'h0, 1);
    chk(irq_o == 1'b0, 1, "irq after reset", {31'd0, irq_o}, 32'd0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule